// File: doc/BRIEF.md
# Convolution Output Checksum Checker

This block detects errors in a K×K convolution engine (stride 1, outputs only where the kernel lies fully inside the frame) while the engine runs. It sits beside the engine and sees two streams: the pixels going into the engine and the results coming out of it. It has no link to the engine's internal state. While pixels stream in, it keeps running sums of the frame: one sum of every pixel, plus sums of the border pixels. A border sum holds the pixels that a given kernel coefficient never meets in any valid output.

When the last result arrives, the block forms a predicted checksum. For each coefficient it takes the total pixel sum, removes that coefficient's border sums, and multiplies the remainder by the coefficient. It adds these products and compares the result with the sum of all results the engine produced. A mismatch raises the fault flag. The block does no convolution of its own and keeps no per-output values.

Top module: `conv_checksum_checker`

## Requirements
- R1: After reset `chk_done_o` and `fault_o` are 0.
- R2: `chk_done_o` is high for exactly the cycle after the cycle in which the (H−K+1)·(W−K+1)-th result of a frame is accepted. If the results sum exactly to the true checksum, `fault_o` is 0 in that cycle.
- R3: If any single result differs from the true convolution value, `fault_o` is 1 when `chk_done_o` is high, whichever result carries the error.
- R4: Pixels are unsigned with DATA_W bits. Coefficients are two's-complement with COEF_W bits. Coefficient (i,j) (kernel row i, kernel column j) sits at bit slice [(i·K+j)·COEF_W +: COEF_W] of `coef_i`. Results are two's-complement with RES_W bits. The prediction is exact for any mix of coefficient signs.
- R5: For coefficient (i,j), only pixels in rows i..H−K+i and columns j..W−K+j count toward that coefficient. Edge and corner pixels are weighted correctly. An engine that drops a corner pixel is flagged.
- R6: `fault_o` keeps its value until the next `chk_done_o`. Each frame is judged only on its own pixels and results, so a clean frame that follows a faulty one reports 0.
- R7: `chk_done_o` is a single-cycle pulse. No pulse occurs except after the final result of a frame.
- R8: Cycles with `pix_valid_i` or `res_valid_i` low have no effect, whatever is on the data inputs.
- R9: The sums do not overflow at the extreme values: every pixel at the maximum, or every coefficient at the most negative value.
- R10: Pixels arrive in raster order, row by row, with H·W pixels per frame. The last result of a frame comes after the last pixel. The next frame starts only after `chk_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_i | input | K·K·COEF_W | Kernel coefficients, packed row-major, held stable during a frame |
| pix_valid_i | input | 1 | Pixel strobe on the engine input stream |
| pix_data_i | input | DATA_W | Pixel value, unsigned |
| res_valid_i | input | 1 | Result strobe on the engine output stream |
| res_data_i | input | RES_W | Engine result, two's complement |
| chk_done_o | output | 1 | One-cycle pulse when a frame has been judged |
| fault_o | output | 1 | Mismatch verdict of the most recent frame |

## Verification
The hardest case to reach is an engine that is wrong only at the frame edge. An error confined to a corner pixel leaves most results correct, and it is caught only if the corner accumulators hold exactly the right pixels. The bench reaches this case by feeding a frame in which only border pixels are nonzero. It checks that frame first with exact reference results and then with results computed as if the top-left pixel were zero. Corrupted results are placed both mid-frame and on the last result. Idle cycles with garbage data are mixed into both streams.

// File: rtl/conv_chk_pkg.sv
package conv_chk_pkg;
  // pixel at pos never meets kernel tap idx in any valid output
  function automatic bit tap_excluded(int pos, int idx, int dim, int ksz);
    return (pos < idx) || (pos > dim - ksz + idx);
  endfunction
endpackage

// File: rtl/chk_raster_pos.sv
module chk_raster_pos #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 64,
  localparam int COL_W = $clog2(IMG_W),
  localparam int ROW_W = $clog2(IMG_H + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clear_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             full_o
);
  assign full_o = (row_o == ROW_W'(IMG_H));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o <= '0;
      col_o <= '0;
    end else if (clear_i) begin
      row_o <= '0;
      col_o <= '0;
    end else if (step_i) begin
      if (col_o == COL_W'(IMG_W - 1)) begin
        col_o <= '0;
        row_o <= row_o + 1'b1;
      end else begin
        col_o <= col_o + 1'b1;
      end
    end
  end

  AST_NO_PIX_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !full_o); // R10
endmodule

// File: rtl/chk_border_acc.sv
module chk_border_acc
  import conv_chk_pkg::*;
#(
  parameter int IMG_W  = 64,
  parameter int IMG_H  = 64,
  parameter int KSZ    = 3,
  parameter int DATA_W = 8,
  localparam int COL_W = $clog2(IMG_W),
  localparam int ROW_W = $clog2(IMG_H + 1),
  localparam int SUM_W = DATA_W + $clog2(IMG_W * IMG_H + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           step_i,
  input  logic                           clear_i,
  input  logic [ROW_W-1:0]               row_i,
  input  logic [COL_W-1:0]               col_i,
  input  logic [DATA_W-1:0]              pix_i,
  output logic [SUM_W-1:0]               total_o,
  output logic [KSZ-1:0][SUM_W-1:0]      row_ex_o,
  output logic [KSZ-1:0][SUM_W-1:0]      col_ex_o,
  output logic [KSZ*KSZ-1:0][SUM_W-1:0]  corner_o
);
  logic [SUM_W-1:0] pix_ext;
  assign pix_ext = SUM_W'(pix_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      total_o <= '0;
    else if (clear_i) total_o <= '0;
    else if (step_i)  total_o <= total_o + pix_ext;
  end

  for (genvar gi = 0; gi < KSZ; gi++) begin : g_band
    logic row_hit, col_hit;
    assign row_hit = tap_excluded(int'(row_i), gi, IMG_H, KSZ);
    assign col_hit = tap_excluded(int'(col_i), gi, IMG_W, KSZ);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_ex_o[gi] <= '0;
        col_ex_o[gi] <= '0;
      end else if (clear_i) begin
        row_ex_o[gi] <= '0;
        col_ex_o[gi] <= '0;
      end else if (step_i) begin
        if (row_hit) row_ex_o[gi] <= row_ex_o[gi] + pix_ext;
        if (col_hit) col_ex_o[gi] <= col_ex_o[gi] + pix_ext;
      end
    end

    AST_TOTAL_COVERS_BORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (total_o >= row_ex_o[gi]) && (total_o >= col_ex_o[gi])); // R5
  end

  // pixels excluded by both row and column; added back once
  for (genvar gi = 0; gi < KSZ; gi++) begin : g_cr
    for (genvar gj = 0; gj < KSZ; gj++) begin : g_cc
      logic hit;
      assign hit = tap_excluded(int'(row_i), gi, IMG_H, KSZ) &&
                   tap_excluded(int'(col_i), gj, IMG_W, KSZ);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             corner_o[gi*KSZ+gj] <= '0;
        else if (clear_i)        corner_o[gi*KSZ+gj] <= '0;
        else if (step_i && hit)  corner_o[gi*KSZ+gj] <= corner_o[gi*KSZ+gj] + pix_ext;
      end
    end
  end
endmodule

// File: rtl/chk_predict.sv
module chk_predict #(
  parameter int KSZ    = 3,
  parameter int COEF_W = 8,
  parameter int SUM_W  = 20,
  parameter int CHK_W  = 40
) (
  input  logic [KSZ*KSZ*COEF_W-1:0]      coef_i,
  input  logic [SUM_W-1:0]               total_i,
  input  logic [KSZ-1:0][SUM_W-1:0]      row_ex_i,
  input  logic [KSZ-1:0][SUM_W-1:0]      col_ex_i,
  input  logic [KSZ*KSZ-1:0][SUM_W-1:0]  corner_i,
  output logic signed [CHK_W-1:0]        pred_o
);
  localparam int NTAP = KSZ * KSZ;

  logic signed [CHK_W-1:0] term [NTAP];

  for (genvar gi = 0; gi < KSZ; gi++) begin : g_r
    for (genvar gj = 0; gj < KSZ; gj++) begin : g_c
      logic signed [CHK_W-1:0] eff, wt;
      assign eff = CHK_W'(total_i) - CHK_W'(row_ex_i[gi]) - CHK_W'(col_ex_i[gj])
                 + CHK_W'(corner_i[gi*KSZ+gj]);
      assign wt  = CHK_W'($signed(coef_i[(gi*KSZ+gj)*COEF_W +: COEF_W]));
      assign term[gi*KSZ+gj] = eff * wt;
    end
  end

  always_comb begin
    pred_o = '0;
    for (int n = 0; n < NTAP; n++) pred_o = pred_o + term[n];
  end
endmodule

// File: rtl/conv_checksum_checker.sv
module conv_checksum_checker #(
  parameter int IMG_W  = 64,
  parameter int IMG_H  = 64,
  parameter int KSZ    = 3,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int RES_W  = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [KSZ*KSZ*COEF_W-1:0] coef_i,
  input  logic                      pix_valid_i,
  input  logic [DATA_W-1:0]         pix_data_i,
  input  logic                      res_valid_i,
  input  logic [RES_W-1:0]          res_data_i,
  output logic                      chk_done_o,
  output logic                      fault_o
);
  localparam int COL_W  = $clog2(IMG_W);
  localparam int ROW_W  = $clog2(IMG_H + 1);
  localparam int SUM_W  = DATA_W + $clog2(IMG_W * IMG_H + 1);
  localparam int CHK_W  = DATA_W + COEF_W + $clog2(IMG_W * IMG_H * KSZ * KSZ) + 8;
  localparam int NRES   = (IMG_H - KSZ + 1) * (IMG_W - KSZ + 1);
  localparam int RCNT_W = $clog2(NRES + 1);

  logic [ROW_W-1:0]              row;
  logic [COL_W-1:0]              col;
  logic                          in_full;
  logic [SUM_W-1:0]              total;
  logic [KSZ-1:0][SUM_W-1:0]     row_ex, col_ex;
  logic [KSZ*KSZ-1:0][SUM_W-1:0] corner;
  logic signed [CHK_W-1:0]       pred, res_acc, res_ext;
  logic [RCNT_W-1:0]             res_cnt;
  logic                          last_res;

  assign last_res = res_valid_i && (res_cnt == RCNT_W'(NRES - 1));
  assign res_ext  = CHK_W'($signed(res_data_i));

  chk_raster_pos #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_pos (
    .clk_i, .rst_ni, .step_i(pix_valid_i), .clear_i(last_res),
    .row_o(row), .col_o(col), .full_o(in_full)
  );

  chk_border_acc #(.IMG_W(IMG_W), .IMG_H(IMG_H), .KSZ(KSZ), .DATA_W(DATA_W)) u_acc (
    .clk_i, .rst_ni, .step_i(pix_valid_i), .clear_i(last_res),
    .row_i(row), .col_i(col), .pix_i(pix_data_i),
    .total_o(total), .row_ex_o(row_ex), .col_ex_o(col_ex), .corner_o(corner)
  );

  chk_predict #(.KSZ(KSZ), .COEF_W(COEF_W), .SUM_W(SUM_W), .CHK_W(CHK_W)) u_pred (
    .coef_i, .total_i(total), .row_ex_i(row_ex), .col_ex_i(col_ex),
    .corner_i(corner), .pred_o(pred)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_acc    <= '0;
      res_cnt    <= '0;
      chk_done_o <= 1'b0;
      fault_o    <= 1'b0;
    end else begin
      chk_done_o <= last_res;
      if (last_res) begin
        fault_o <= (pred != res_acc + res_ext);
        res_acc <= '0;
        res_cnt <= '0;
      end else if (res_valid_i) begin
        res_acc <= res_acc + res_ext;
        res_cnt <= res_cnt + 1'b1;
      end
    end
  end

  AST_LAST_RES_AFTER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_res |-> in_full); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_done_o |=> !chk_done_o); // R7
  AST_DONE_FOLLOWS_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_done_o |-> $past(res_valid_i)); // R2
  AST_FAULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_done_o |-> $stable(fault_o)); // R6
endmodule

// File: tb/conv_checksum_checker_test.sv
module conv_checksum_checker_test;
  localparam int W = 7, H = 5, K = 3, DW = 8, CW = 8, RW = 24;
  localparam int OH = H - K + 1, OW = W - K + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [K*K*CW-1:0] coef = '0;
  logic pix_valid = 1'b0, res_valid = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic [RW-1:0] res_data = '0;
  logic done, fault;

  conv_checksum_checker #(.IMG_W(W), .IMG_H(H), .KSZ(K), .DATA_W(DW), .COEF_W(CW), .RES_W(RW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .coef_i(coef), .pix_valid_i(pix_valid), .pix_data_i(pix_data),
    .res_valid_i(res_valid), .res_data_i(res_data), .chk_done_o(done), .fault_o(fault)
  );

  always #2ns clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  int img [H][W];
  int wt  [K][K];
  int exp_fault_q [$];
  int exp_cyc_q   [$];
  string tag_q    [$];
  bit prev_done = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops expected verdicts as the checker reports
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(done == 1'b0, "R7 pulse width", done, 0);
      if (done) begin
        if (exp_fault_q.size() == 0) chk(1'b0, "R7 unexpected done", 1, 0);
        else begin
          int ef, ec;
          string tg;
          ef = exp_fault_q.pop_front();
          ec = exp_cyc_q.pop_front();
          tg = tag_q.pop_front();
          chk(cyc == ec, "R2 done timing", cyc, ec);
          chk(fault == ef[0], tg, fault, ef);
        end
      end
      prev_done = done;
    end
  end

  task automatic set_coef();
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++)
        coef[(i*K+j)*CW +: CW] = CW'(wt[i][j]);
  endtask

  task automatic idle_gap();
    while ($urandom_range(0, 2) == 0) begin
      pix_valid = 1'b0; res_valid = 1'b0;
      pix_data = DW'($urandom); res_data = RW'($urandom);
      @(negedge clk);
    end
  endtask

  // driver: engine model; bad_idx/delta corrupt one result, drop_c zeroes pixel (0,0) in the model
  task automatic run_frame(int bad_idx, int delta, bit drop_c, string tag);
    int outs [OH*OW];
    int ef;
    ef = 0;
    for (int r = 0; r < OH; r++)
      for (int c = 0; c < OW; c++) begin
        int s, sr;
        s = 0; sr = 0;
        for (int i = 0; i < K; i++)
          for (int j = 0; j < K; j++) begin
            int px;
            px = img[r+i][c+j];
            sr += px * wt[i][j];
            if (drop_c && r+i == 0 && c+j == 0) px = 0;
            s += px * wt[i][j];
          end
        if (r*OW+c == bad_idx) s += delta;
        if (s != sr) ef = 1;
        outs[r*OW+c] = s;
      end
    set_coef();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        idle_gap();
        pix_valid = 1'b1; pix_data = DW'(img[r][c]);
        @(negedge clk);
      end
    pix_valid = 1'b0; pix_data = DW'($urandom);
    repeat (2) @(negedge clk);
    for (int n = 0; n < OH*OW; n++) begin
      idle_gap();
      res_valid = 1'b1; res_data = RW'(outs[n]);
      if (n == OH*OW-1) begin
        exp_fault_q.push_back(ef); exp_cyc_q.push_back(cyc + 1); tag_q.push_back(tag);
      end
      @(negedge clk);
    end
    res_valid = 1'b0; res_data = RW'($urandom);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done at reset", done, 0);
    chk(fault == 1'b0, "R1 fault at reset", fault, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && fault == 1'b0, "R1 after release", {done, fault}, 0);

    // mixed-sign coefficients, ramp image
    for (int i = 0; i < K; i++) for (int j = 0; j < K; j++) wt[i][j] = (i*K+j)*13 - 50;
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = (r*37 + c*11 + 5) % 256;
    run_frame(-1, 0, 0, "R4 clean mixed signs");
    run_frame(7, 1, 0, "R3 mid result off by one");
    run_frame(OH*OW-1, -300, 0, "R3 last result corrupted");
    repeat (10) @(negedge clk);
    chk(fault == 1'b1, "R6 fault held", fault, 1);
    run_frame(-1, 0, 0, "R6 clean after fault");

    // border-only frame
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++)
      img[r][c] = (r == 0 || r == H-1 || c == 0 || c == W-1) ? 180 + r + c : 0;
    run_frame(-1, 0, 0, "R5 border clean");
    run_frame(-1, 0, 1, "R5 corner pixel dropped");

    // extremes
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = 255;
    for (int i = 0; i < K; i++) for (int j = 0; j < K; j++) wt[i][j] = -128;
    run_frame(-1, 0, 0, "R9 extreme clean");
    run_frame(4, 1 << 20, 0, "R9 extreme corrupted");
    for (int i = 0; i < K; i++) for (int j = 0; j < K; j++) wt[i][j] = ((i+j) % 2 == 0) ? 127 : -128;
    run_frame(-1, 0, 0, "R8 R9 alternating clean");

    chk(exp_fault_q.size() == 0, "R7 all frames reported", exp_fault_q.size(), 0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end
endmodule